// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencing Controller

This block decides what the command pins of an SDRAM carry whenever the memory is not serving an ordinary read or write. It moves the device between three regimes: normal operation, periodic auto-refresh, and self-refresh, where the device keeps its own contents alive with the clock enable held low. The controls arrive as level bits from a register bank: a refresh enable, a self-refresh mode select, two 2-bit gap fields and a refresh counter preload with its compare value.

Self-refresh entry and auto-refresh use the same path. The sequencer waits until open banks have finished precharging, issues a precharge-all, idles for the row-precharge gap, and then issues either SELF or REF. Leaving self-refresh sends an exit command, raises clock enable and idles for the row-cycle gap before normal traffic resumes. While the sequencer owns the bus it holds `busy`, and the access logic must treat that as a refused grant. A manual reset only clears the refresh timer. A power-on reset returns the whole block to normal operation.

Top module: `sdram_selfref_ctrl`

## Requirements
- R1: Self-refresh entry starts only when `refresh_en` and `self_mode` are both 1. With `refresh_en` at 0 an idle sequencer keeps `busy` at 0.
- R2: Once entry or an auto-refresh starts, `busy` is 1 and NOP is driven while `bank_pc_done` is 0. PALL appears in the cycle after `bank_pc_done` is sampled at 1.
- R3: After PALL, the sequencer drives exactly `trp_wait` (0 to 3) NOP cycles and then SELF, with `sd_cke` low in the SELF cycle.
- R4: In self-refresh, `sd_cke` is 0, `busy` is 1 and NOP is driven. Asserting `standby` or `mrst` changes none of these.
- R5: The cycle after `self_mode` is sampled at 0 in self-refresh carries the exit command with `sd_cke` at 1. Then exactly `trc_wait` NOP cycles follow with `busy` at 1, and after that `busy` returns to 0.
- R6: The refresh counter advances each cycle while `refresh_en` is 1, `self_mode` is 0 and `standby` is 0. When the incremented value equals `cnt_cmp` it raises a request and restarts from zero. A `cnt_load` pulse writes `cnt_load_val`, so a preload of `cnt_cmp - 1` raises the request on the next count. `standby` freezes the count.
- R7: An auto-refresh request is taken only while `acc_active` is 0. The sequence is: wait for precharge, PALL, `trp_wait` NOPs, REF, `trc_wait` NOPs, normal.
- R8: While `por_n` is 0 (asynchronous), the outputs are NOP, `sd_cke` at 1 and `busy` at 0. The refresh counter and any pending request are cleared.
- R9: Command codes on `sd_cmd` are NOP=0, PALL=1, REF=2, SELF=3, self-refresh exit=4. Any code other than NOP appears only while `busy` is 1.
- R10: `mrst` clears the refresh counter and any pending request without changing the sequencer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst | input | 1 | Manual reset, synchronous, active high; clears the refresh timer only |
| standby | input | 1 | Chip standby indication; freezes the refresh counter |
| refresh_en | input | 1 | Refresh enable control bit |
| self_mode | input | 1 | Selects self-refresh when set together with refresh_en |
| trp_wait | input | WAIT_W | Idle cycles between PALL and SELF/REF |
| trc_wait | input | WAIT_W | Idle cycles after exit or REF |
| cnt_load | input | 1 | Writes cnt_load_val into the refresh counter |
| cnt_load_val | input | CNT_W | Refresh counter preload value |
| cnt_cmp | input | CNT_W | Refresh compare value |
| bank_pc_done | input | 1 | All bank precharges complete |
| acc_active | input | 1 | A normal access is in flight |
| sd_cmd | output | 3 | SDRAM command code |
| sd_cke | output | 1 | SDRAM clock enable |
| busy | output | 1 | Sequencer owns the bus; normal accesses refused |

## Verification
The bound checker checks on every cycle the rules that relate one cycle to the next. A low clock enable always comes with `busy` and with either SELF or NOP. Clock enable stays low while the mode bit stays set. The exit command follows a low-enable cycle. PALL follows a sampled precharge-done. No command other than NOP appears outside `busy`. An idle sequencer with refresh disabled never starts. Only the bench scenarios can show the exact lengths of the gaps, the counter preload and the cycle in which the request fires, the freeze during standby, the request held back by an in-flight access, and the asynchronous power-on return from self-refresh.

// File: rtl/sref_pkg.sv
package sref_pkg;

   typedef enum logic [2:0] {
      CMD_NOP  = 3'd0,
      CMD_PALL = 3'd1,
      CMD_REF  = 3'd2,
      CMD_SELF = 3'd3,
      CMD_SRX  = 3'd4
   } sd_cmd_e;

   typedef enum logic [3:0] {
      ST_NORM,
      ST_DRAIN,
      ST_PALL,
      ST_TRP,
      ST_SELF,
      ST_SREF,
      ST_SRX,
      ST_REF,
      ST_TRC
   } seq_st_e;

endpackage

// File: rtl/sref_wait_timer.sv
// Down-counting gap timer: load a count, then last is high on the final idle cycle.
module sref_wait_timer #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         last
);

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] rem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem <= '0;
      end else if (load) begin
         rem <= load_val;
      end else if (rem != '0) begin
         rem <= rem - ONE;
      end
   end

   assign last = (rem <= ONE);

endmodule

// File: rtl/sref_refresh_timer.sv
// Free-running refresh interval counter with preload and a sticky request.
module sref_refresh_timer #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] cmp,
   input  logic             drop,
   output logic             req
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc = cnt + ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         req <= 1'b0;
      end else if (clr) begin
         cnt <= '0;
         req <= 1'b0;
      end else begin
         if (drop) begin
            req <= 1'b0;
         end
         if (load) begin
            cnt <= load_val;
         end else if (run) begin
            if (cnt_inc == cmp) begin
               cnt <= '0;
               req <= 1'b1;
            end else begin
               cnt <= cnt_inc;
            end
         end
      end
   end

endmodule

// File: rtl/sdram_selfref_ctrl.sv
module sdram_selfref_ctrl
   import sref_pkg::*;
#(
   parameter int CNT_W          = 10,
   parameter int WAIT_W         = 2,
   parameter bit CKE_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              mrst,
   input  logic              standby,
   input  logic              refresh_en,
   input  logic              self_mode,
   input  logic [WAIT_W-1:0] trp_wait,
   input  logic [WAIT_W-1:0] trc_wait,
   input  logic              cnt_load,
   input  logic [CNT_W-1:0]  cnt_load_val,
   input  logic [CNT_W-1:0]  cnt_cmp,
   input  logic              bank_pc_done,
   input  logic              acc_active,
   output logic [2:0]        sd_cmd,
   output logic              sd_cke,
   output logic              busy
);

   localparam logic [WAIT_W-1:0] GAP_NONE = '0;

   generate
      if (CNT_W < 2 || CNT_W > 24) begin : g_bad_cnt_w
         $error("sdram_selfref_ctrl: CNT_W out of range");
      end
      if (WAIT_W < 1 || WAIT_W > 8) begin : g_bad_wait_w
         $error("sdram_selfref_ctrl: WAIT_W out of range");
      end
   endgenerate

   seq_st_e           st, st_nxt;
   logic              is_self;
   logic              is_self_nxt;
   logic              gap_load;
   logic [WAIT_W-1:0] gap_val;
   logic              gap_last;
   logic              ref_req;
   logic              ref_ack;
   logic              cnt_run;
   logic              want_self;
   logic              want_ref;

   // Refresh interval timer
   assign cnt_run = refresh_en && !self_mode && !standby;
   assign ref_ack = (st == ST_NORM) && (st_nxt != ST_NORM);

   sref_refresh_timer #(.CNT_W(CNT_W)) u_rtimer (
      .clk      (clk),
      .rst_n    (por_n),
      .clr      (mrst),
      .run      (cnt_run),
      .load     (cnt_load),
      .load_val (cnt_load_val),
      .cmp      (cnt_cmp),
      .drop     (ref_ack || !refresh_en),
      .req      (ref_req)
   );

   // Gap timer shared by the precharge and row-cycle waits
   assign gap_load = (st == ST_PALL) || (st == ST_SRX) || (st == ST_REF);
   assign gap_val  = (st == ST_PALL) ? trp_wait : trc_wait;

   sref_wait_timer #(.W(WAIT_W)) u_gap (
      .clk      (clk),
      .rst_n    (por_n),
      .load     (gap_load),
      .load_val (gap_val),
      .last     (gap_last)
   );

   // Sequencer
   assign want_self = refresh_en && self_mode;
   assign want_ref  = ref_req && refresh_en && !self_mode && !acc_active;

   always_comb begin
      st_nxt      = st;
      is_self_nxt = is_self;
      unique case (st)
         ST_NORM: begin
            if (want_self) begin
               st_nxt      = ST_DRAIN;
               is_self_nxt = 1'b1;
            end else if (want_ref) begin
               st_nxt      = ST_DRAIN;
               is_self_nxt = 1'b0;
            end
         end
         ST_DRAIN: if (bank_pc_done) st_nxt = ST_PALL;
         ST_PALL: begin
            if (trp_wait == GAP_NONE) st_nxt = is_self ? ST_SELF : ST_REF;
            else                      st_nxt = ST_TRP;
         end
         ST_TRP:  if (gap_last) st_nxt = is_self ? ST_SELF : ST_REF;
         ST_SELF: st_nxt = ST_SREF;
         ST_SREF: if (!self_mode) st_nxt = ST_SRX;
         ST_SRX, ST_REF: begin
            if (trc_wait == GAP_NONE) st_nxt = ST_NORM;
            else                      st_nxt = ST_TRC;
         end
         ST_TRC:  if (gap_last) st_nxt = ST_NORM;
         default: st_nxt = ST_NORM;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         st      <= ST_NORM;
         is_self <= 1'b0;
      end else begin
         st      <= st_nxt;
         is_self <= is_self_nxt;
      end
   end

   // Command decode
   always_comb begin
      unique case (st)
         ST_PALL: sd_cmd = CMD_PALL;
         ST_SELF: sd_cmd = CMD_SELF;
         ST_SRX:  sd_cmd = CMD_SRX;
         ST_REF:  sd_cmd = CMD_REF;
         default: sd_cmd = CMD_NOP;
      endcase
   end

   assign busy = (st != ST_NORM);

   // Clock enable: same timing either way, choice is glitch-free register or fewer flops
   generate
      if (CKE_REGISTERED) begin : g_cke_reg
         logic cke_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) cke_q <= 1'b1;
            else        cke_q <= !((st_nxt == ST_SELF) || (st_nxt == ST_SREF));
         end
         assign sd_cke = cke_q;
      end else begin : g_cke_comb
         assign sd_cke = !((st == ST_SELF) || (st == ST_SREF));
      end
   endgenerate

endmodule

// File: rtl/sref_ctrl_checker.sv
module sref_ctrl_checker (
   input logic       clk,
   input logic       por_n,
   input logic       refresh_en,
   input logic       self_mode,
   input logic       bank_pc_done,
   input logic [2:0] sd_cmd,
   input logic       sd_cke,
   input logic       busy
);

   // R9: non-NOP commands only while the sequencer owns the bus
   a_r9_cmd_needs_busy: assert property (@(posedge clk) disable iff (!por_n)
      (sd_cmd != 3'd0) |-> busy);

   // R4: low clock enable only in self-refresh, which blocks access and drives SELF or NOP
   a_r4_cke_low_busy: assert property (@(posedge clk) disable iff (!por_n)
      !sd_cke |-> (busy && (sd_cmd == 3'd3 || sd_cmd == 3'd0)));

   // R4: self-refresh is held while the mode bit stays set
   a_r4_hold_self: assert property (@(posedge clk) disable iff (!por_n)
      (!sd_cke && self_mode) |=> !sd_cke);

   // R5: exit command raises clock enable after a low-enable cycle
   a_r5_exit_cke: assert property (@(posedge clk) disable iff (!por_n)
      (sd_cmd == 3'd4) |-> (sd_cke && $past(!sd_cke)));

   // R3: SELF directly follows PALL or an idle gap cycle
   a_r3_self_after_gap: assert property (@(posedge clk) disable iff (!por_n)
      (sd_cmd == 3'd3) |-> ($past(sd_cmd) == 3'd1 || $past(sd_cmd) == 3'd0));

   // R2: PALL only after precharge-done was sampled during a sequence
   a_r2_pall_after_done: assert property (@(posedge clk) disable iff (!por_n)
      (sd_cmd == 3'd1) |-> ($past(bank_pc_done) && $past(busy)));

   // R1: with refresh disabled an idle sequencer stays idle
   a_r1_no_start: assert property (@(posedge clk) disable iff (!por_n)
      (!busy && !refresh_en) |=> !busy);

endmodule

bind sdram_selfref_ctrl sref_ctrl_checker u_chk (
   .clk          (clk),
   .por_n        (por_n),
   .refresh_en   (refresh_en),
   .self_mode    (self_mode),
   .bank_pc_done (bank_pc_done),
   .sd_cmd       (sd_cmd),
   .sd_cke       (sd_cke),
   .busy         (busy)
);

// File: tb/sdram_selfref_ctrl_tb.sv
module sdram_selfref_ctrl_tb;

   localparam int CNT_W  = 10;
   localparam int WAIT_W = 2;
   localparam int NVEC   = 15;

   logic              clk = 1'b0;
   logic              por_n;
   logic              mrst;
   logic              standby;
   logic              refresh_en;
   logic              self_mode;
   logic [WAIT_W-1:0] trp_wait;
   logic [WAIT_W-1:0] trc_wait;
   logic              cnt_load;
   logic [CNT_W-1:0]  cnt_load_val;
   logic [CNT_W-1:0]  cnt_cmp;
   logic              bank_pc_done;
   logic              acc_active;
   logic [2:0]        sd_cmd;
   logic              sd_cke;
   logic              busy;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   sdram_selfref_ctrl #(.CNT_W(CNT_W), .WAIT_W(WAIT_W)) u_dut (
      .clk(clk), .por_n(por_n), .mrst(mrst), .standby(standby),
      .refresh_en(refresh_en), .self_mode(self_mode),
      .trp_wait(trp_wait), .trc_wait(trc_wait),
      .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .cnt_cmp(cnt_cmp),
      .bank_pc_done(bank_pc_done), .acc_active(acc_active),
      .sd_cmd(sd_cmd), .sd_cke(sd_cke), .busy(busy)
   );

   // {tag[14:11], en, mode, pcd, acc, stby, mrst, cmd[4:2], cke, busy}; trp_wait=2, trc_wait=1
   localparam logic [14:0] VEC [NVEC] = '{
      {4'd9, 6'b100000, 3'd0, 1'b1, 1'b0},  // R9 normal idle
      {4'd2, 6'b110000, 3'd0, 1'b1, 1'b1},  // R2 entry, waiting for precharge
      {4'd2, 6'b110000, 3'd0, 1'b1, 1'b1},  // R2 still waiting
      {4'd2, 6'b111000, 3'd1, 1'b1, 1'b1},  // R2 PALL after done
      {4'd3, 6'b110000, 3'd0, 1'b1, 1'b1},  // R3 gap 1
      {4'd3, 6'b110000, 3'd0, 1'b1, 1'b1},  // R3 gap 2
      {4'd3, 6'b110000, 3'd3, 1'b0, 1'b1},  // R3 SELF, cke low
      {4'd4, 6'b110000, 3'd0, 1'b0, 1'b1},  // R4 self-refresh
      {4'd4, 6'b110010, 3'd0, 1'b0, 1'b1},  // R4 standby ignored
      {4'd4, 6'b110011, 3'd0, 1'b0, 1'b1},  // R4 manual reset ignored
      {4'd5, 6'b100000, 3'd4, 1'b1, 1'b1},  // R5 exit
      {4'd5, 6'b100000, 3'd0, 1'b1, 1'b1},  // R5 row-cycle gap
      {4'd5, 6'b100000, 3'd0, 1'b1, 1'b0},  // R5 back to normal
      {4'd1, 6'b011000, 3'd0, 1'b1, 1'b0},  // R1 mode without enable
      {4'd1, 6'b011000, 3'd0, 1'b1, 1'b0}   // R1 still idle
   };

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string tag, input logic [2:0] ec, input logic ek, input logic eb);
      n_tests++;
      if (sd_cmd !== ec || sd_cke !== ek || busy !== eb) begin
         n_fail++;
         $display("FAIL %s: cmd=%0d cke=%b busy=%b expected cmd=%0d cke=%b busy=%b",
                  tag, sd_cmd, sd_cke, busy, ec, ek, eb);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R9 watchdog: run did not complete, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      por_n = 1'b0; mrst = 1'b0; standby = 1'b0;
      refresh_en = 1'b0; self_mode = 1'b0;
      trp_wait = 2'd2; trc_wait = 2'd1;
      cnt_load = 1'b0; cnt_load_val = '0; cnt_cmp = 10'd1000;
      bank_pc_done = 1'b0; acc_active = 1'b0;
      repeat (3) tick();
      chk("R8 reset", 3'd0, 1'b1, 1'b0);
      por_n = 1'b1;

      // Vector walk
      for (int i = 0; i < NVEC; i++) begin
         refresh_en   = VEC[i][10];
         self_mode    = VEC[i][9];
         bank_pc_done = VEC[i][8];
         acc_active   = VEC[i][7];
         standby      = VEC[i][6];
         mrst         = VEC[i][5];
         tick();
         chk($sformatf("R%0d vec%0d", VEC[i][14:11], i), VEC[i][4:2], VEC[i][1], VEC[i][0]);
      end
      standby = 1'b0; mrst = 1'b0;

      // R3 / R5 zero-length gaps
      trp_wait = 2'd0; trc_wait = 2'd0;
      refresh_en = 1'b1; self_mode = 1'b1; bank_pc_done = 1'b1;
      tick(); chk("R2 zero-gap drain", 3'd0, 1'b1, 1'b1);
      tick(); chk("R2 zero-gap PALL", 3'd1, 1'b1, 1'b1);
      tick(); chk("R3 zero-gap SELF", 3'd3, 1'b0, 1'b1);
      tick(); chk("R4 zero-gap hold", 3'd0, 1'b0, 1'b1);
      self_mode = 1'b0;
      tick(); chk("R5 zero-gap exit", 3'd4, 1'b1, 1'b1);
      tick(); chk("R5 zero-gap normal", 3'd0, 1'b1, 1'b0);

      // R6 preload, R7 auto-refresh held off by access
      trp_wait = 2'd1; trc_wait = 2'd1; cnt_cmp = 10'd20;
      acc_active = 1'b1; cnt_load = 1'b1; cnt_load_val = 10'd19;
      tick(); chk("R6 preload", 3'd0, 1'b1, 1'b0);
      cnt_load = 1'b0;
      tick(); chk("R6 request raised", 3'd0, 1'b1, 1'b0);
      tick(); chk("R7 held by access", 3'd0, 1'b1, 1'b0);
      tick(); chk("R7 still held", 3'd0, 1'b1, 1'b0);
      acc_active = 1'b0;
      tick(); chk("R7 drain", 3'd0, 1'b1, 1'b1);
      tick(); chk("R7 PALL", 3'd1, 1'b1, 1'b1);
      tick(); chk("R7 trp gap", 3'd0, 1'b1, 1'b1);
      tick(); chk("R7 REF", 3'd2, 1'b1, 1'b1);
      tick(); chk("R7 trc gap", 3'd0, 1'b1, 1'b1);
      tick(); chk("R7 normal", 3'd0, 1'b1, 1'b0);
      refresh_en = 1'b0;
      tick();

      // R6 standby freezes the counter
      refresh_en = 1'b1; standby = 1'b1; cnt_load = 1'b1; cnt_load_val = 10'd19;
      tick();
      cnt_load = 1'b0;
      for (int k = 0; k < 4; k++) begin
         tick(); chk("R6 frozen in standby", 3'd0, 1'b1, 1'b0);
      end
      standby = 1'b0;
      tick(); chk("R6 request after standby", 3'd0, 1'b1, 1'b0);
      tick(); chk("R7 refresh starts", 3'd0, 1'b1, 1'b1);
      refresh_en = 1'b0;
      repeat (6) tick();
      chk("R7 sequence completes", 3'd0, 1'b1, 1'b0);

      // R10 manual reset clears a pending preload
      refresh_en = 1'b1; cnt_load = 1'b1; cnt_load_val = 10'd19;
      tick();
      cnt_load = 1'b0; mrst = 1'b1;
      tick(); chk("R10 reset cycle", 3'd0, 1'b1, 1'b0);
      mrst = 1'b0;
      for (int k = 0; k < 3; k++) begin
         tick(); chk("R10 no refresh", 3'd0, 1'b1, 1'b0);
      end
      refresh_en = 1'b0;
      tick();

      // R8 power-on reset leaves self-refresh
      trp_wait = 2'd0; trc_wait = 2'd0;
      refresh_en = 1'b1; self_mode = 1'b1; bank_pc_done = 1'b1;
      repeat (4) tick();
      chk("R4 in self-refresh", 3'd0, 1'b0, 1'b1);
      por_n = 1'b0; refresh_en = 1'b0; self_mode = 1'b0;
      #1;
      chk("R8 async reset", 3'd0, 1'b1, 1'b0);
      tick(); chk("R8 held", 3'd0, 1'b1, 1'b0);
      por_n = 1'b1;
      tick(); chk("R8 normal after reset", 3'd0, 1'b1, 1'b0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule